// File: doc/BRIEF.md
# Speculative Load Conflict Table

This block tracks loads that a schedule has moved above earlier stores. When such a load issues early, the table records the word it read, keyed by the load's destination register number. Every store that follows is compared against all live records, and a record whose word matches is flagged as conflicting. At the place the load originally sat in program order, a check operation queries the record by the same register number. The response says whether the load must be replayed.

The table has a fixed number of entries, 16 by default. When an allocation finds the table full, it takes over an entry chosen by a round-robin pointer. A check that finds no record answers "replay", so a lost record can never hide a conflict. Each check consumes its record. Within one clock cycle the three ports are ordered as store first, then check, then allocate. The check response appears one cycle after the check is presented.

Top module: `spec_load_table`

## Requirements
- R1: After synchronous reset, rsp_valid is low and no entry is live, so the first check of any tag answers rsp_replay = 1.
- R2: A check of a tag that was allocated and not touched by any store since answers rsp_replay = 0.
- R3: A store whose word address (address bits 31:2) equals a live entry's word address marks that entry, and its later check answers rsp_replay = 1. The byte offset in bits 1:0 is ignored.
- R4: A store to a different word leaves an entry unmarked, so its check still answers rsp_replay = 0.
- R5: A check whose tag matches no live entry answers rsp_replay = 1.
- R6: A check consumes its entry whatever the result, so a second check of the same tag answers rsp_replay = 1.
- R7: Allocations into an empty table fill entries 0, 1, 2 and so on in order. When the table is full and the tag is not present, the allocation replaces the entry at a round-robin pointer. The pointer starts at 0 after reset and advances by one after each such replacement. A check of the evicted tag answers rsp_replay = 1.
- R8: A store and an allocation to the same word in the same cycle are ordered store first, so the new entry is not marked.
- R9: Allocating a tag that is already live overwrites that entry in place and clears its mark. At most one live entry carries a given tag.
- R10: rsp_valid is high exactly in the cycle after each cycle with chk_valid high, and low otherwise.
- R11: A store presented in the same cycle as a check is older than the check. If it matches the checked entry, the answer is rsp_replay = 1.
- R12: An allocation takes the lowest free entry whenever one exists. In that case no live entry is replaced and the round-robin pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Speculative load issues this cycle |
| alloc_tag | input | 6 | Destination register number of the load |
| alloc_addr | input | 32 | Load address |
| probe_valid | input | 1 | Store probes the table this cycle |
| probe_addr | input | 32 | Store address |
| chk_valid | input | 1 | Check operation this cycle |
| chk_tag | input | 6 | Register number being checked |
| rsp_valid | output | 1 | Check response valid (one cycle after chk_valid) |
| rsp_replay | output | 1 | 1: the load must be re-executed |

## Verification
The conflict detection is driven with several store patterns. A store to the same word at a different byte offset must flag the entry, while a store to a neighbouring word must not; this separates word-granular matching from exact or overly coarse matching. Stores are also presented in the same cycle as an allocation and in the same cycle as a check. These two cases tell apart the intended ordering (store first) from its reverse. Filling the table, evicting, freeing one slot and refilling shows the difference between preferring a free slot and always using the round-robin pointer, and also shows whether the pointer moves only on a real replacement.

// File: rtl/sl_pkg.sv
package sl_pkg;

    localparam int unsigned SL_ENTRIES  = 16;
    localparam int unsigned SL_TAG_W    = 6;
    localparam int unsigned SL_ADDR_W   = 32;
    localparam int unsigned SL_WORD_LSB = 2;
    localparam int unsigned SL_WORD_W   = SL_ADDR_W - SL_WORD_LSB;

    typedef logic [SL_TAG_W-1:0]  tag_t;
    typedef logic [SL_ADDR_W-1:0] addr_t;
    typedef logic [SL_WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        logic  violated;
        tag_t  tag;
        word_t word;
    } entry_t;

    typedef enum logic [1:0] {
        ALLOC_NONE,
        ALLOC_REUSE,
        ALLOC_FREE,
        ALLOC_EVICT
    } alloc_kind_t;

    function automatic word_t word_of(input addr_t a);
        return a[SL_ADDR_W-1:SL_WORD_LSB];
    endfunction

endpackage

// File: rtl/sl_entry.sv
module sl_entry
    import sl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  tag_t   wr_tag,
    input  word_t  wr_word,
    input  logic   clr_en,
    input  logic   probe_valid,
    input  word_t  probe_word,
    output entry_t state,
    output logic   probe_hit
);

    always_comb begin
        probe_hit = probe_valid && state.valid && (state.word == probe_word);
    end

    // Priority: allocate (youngest) > check clear > store mark (oldest)
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (wr_en) begin
            state.valid    <= 1'b1;
            state.violated <= 1'b0;
            state.tag      <= wr_tag;
            state.word     <= wr_word;
        end else if (clr_en) begin
            state.valid    <= 1'b0;
            state.violated <= 1'b0;
        end else if (probe_hit) begin
            state.violated <= 1'b1;
        end
    end

    p_probe_marks_r3: assert property (@(posedge clk) disable iff (rst)
        (probe_hit && !wr_en && !clr_en) |=> (state.valid && state.violated));

    p_fresh_clean_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (state.valid && !state.violated));

    p_consume_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !wr_en) |=> !state.valid);

endmodule

// File: rtl/sl_alloc_sel.sv
module sl_alloc_sel
    import sl_pkg::*;
#(
    parameter int unsigned N = SL_ENTRIES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         alloc_valid,
    input  tag_t         alloc_tag,
    input  entry_t       ents [N],
    output logic [N-1:0] wr_sel
);

    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [N-1:0]     tag_hit;
    logic [N-1:0]     free_vec;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] ptr;
    alloc_kind_t      kind;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            tag_hit[i]  = ents[i].valid && (ents[i].tag == alloc_tag);
            free_vec[i] = !ents[i].valid;
        end
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        kind   = ALLOC_NONE;
        wr_sel = '0;
        if (alloc_valid) begin
            if (|tag_hit) begin
                kind   = ALLOC_REUSE;
                wr_sel = tag_hit;
            end else if (|free_vec) begin
                kind             = ALLOC_FREE;
                wr_sel[free_idx] = 1'b1;
            end else begin
                kind        = ALLOC_EVICT;
                wr_sel[ptr] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (kind == ALLOC_EVICT) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    p_unique_tag_r9: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> $onehot0(tag_hit));

    p_single_write_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel));

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (kind == ALLOC_EVICT) |=>
            (ptr == (($past(ptr) == LAST) ? '0 : IDX_W'($past(ptr) + 1'b1))));

    p_ptr_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (kind != ALLOC_EVICT) |=> $stable(ptr));

endmodule

// File: rtl/sl_check_port.sv
module sl_check_port
    import sl_pkg::*;
#(
    parameter int unsigned N = SL_ENTRIES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chk_valid,
    input  tag_t         chk_tag,
    input  entry_t       ents [N],
    input  logic [N-1:0] probe_hit,
    output logic [N-1:0] clr,
    output logic         rsp_valid,
    output logic         rsp_replay
);

    logic [N-1:0] hit;
    logic [N-1:0] marked;
    logic         found;
    logic         conflict;
    logic         replay_d;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit[i]    = ents[i].valid && (ents[i].tag == chk_tag);
            // a same-cycle store is older than the check
            marked[i] = ents[i].violated || probe_hit[i];
        end
        found    = |hit;
        conflict = |(hit & marked);
        replay_d = !found || conflict;
        clr      = chk_valid ? hit : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_replay <= 1'b0;
        end else begin
            rsp_valid  <= chk_valid;
            rsp_replay <= chk_valid && replay_d;
        end
    end

    p_rsp_after_chk_r10: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> rsp_valid);

    p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !rsp_valid);

    p_miss_replay_r5: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !found) |=> rsp_replay);

    p_conflict_replay_r3: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && conflict) |=> rsp_replay);

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
    import sl_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = SL_ENTRIES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_valid,
    input  logic [SL_TAG_W-1:0]  alloc_tag,
    input  logic [SL_ADDR_W-1:0] alloc_addr,
    input  logic                 probe_valid,
    input  logic [SL_ADDR_W-1:0] probe_addr,
    input  logic                 chk_valid,
    input  logic [SL_TAG_W-1:0]  chk_tag,
    output logic                 rsp_valid,
    output logic                 rsp_replay
);

    entry_t                 ents [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] wr_sel;
    logic [NUM_ENTRIES-1:0] clr;
    logic [NUM_ENTRIES-1:0] probe_hit;
    word_t                  alloc_word;
    word_t                  probe_word;

    always_comb begin
        alloc_word = word_of(alloc_addr);
        probe_word = word_of(probe_addr);
    end

    sl_alloc_sel #(.N(NUM_ENTRIES)) u_alloc (
        .clk         (clk),
        .rst         (rst),
        .alloc_valid (alloc_valid),
        .alloc_tag   (alloc_tag),
        .ents        (ents),
        .wr_sel      (wr_sel)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        sl_entry u_ent (
            .clk         (clk),
            .rst         (rst),
            .wr_en       (wr_sel[g]),
            .wr_tag      (alloc_tag),
            .wr_word     (alloc_word),
            .clr_en      (clr[g]),
            .probe_valid (probe_valid),
            .probe_word  (probe_word),
            .state       (ents[g]),
            .probe_hit   (probe_hit[g])
        );
    end

    sl_check_port #(.N(NUM_ENTRIES)) u_check (
        .clk        (clk),
        .rst        (rst),
        .chk_valid  (chk_valid),
        .chk_tag    (chk_tag),
        .ents       (ents),
        .probe_hit  (probe_hit),
        .clr        (clr),
        .rsp_valid  (rsp_valid),
        .rsp_replay (rsp_replay)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !rsp_valid);

endmodule

// File: tb/spec_load_table_tb.sv
module spec_load_table_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        alloc_valid;
    logic [5:0]  alloc_tag;
    logic [31:0] alloc_addr;
    logic        probe_valid;
    logic [31:0] probe_addr;
    logic        chk_valid;
    logic [5:0]  chk_tag;
    logic        rsp_valid;
    logic        rsp_replay;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    spec_load_table u_dut (
        .clk         (clk),
        .rst         (rst),
        .alloc_valid (alloc_valid),
        .alloc_tag   (alloc_tag),
        .alloc_addr  (alloc_addr),
        .probe_valid (probe_valid),
        .probe_addr  (probe_addr),
        .chk_valid   (chk_valid),
        .chk_tag     (chk_tag),
        .rsp_valid   (rsp_valid),
        .rsp_replay  (rsp_replay)
    );

    task automatic expect_bit(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, inputs captured at posedge, result read at next negedge
    task automatic cyc(input logic av, input logic [5:0] at, input logic [31:0] aa,
                       input logic pv, input logic [31:0] pa,
                       input logic cv, input logic [5:0] ct,
                       input logic exp_replay, input string req);
        alloc_valid = av; alloc_tag = at; alloc_addr = aa;
        probe_valid = pv; probe_addr = pa;
        chk_valid = cv; chk_tag = ct;
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 1'b0; probe_valid = 1'b0; chk_valid = 1'b0;
        if (cv) begin
            expect_bit(rsp_valid, 1'b1, {req, " R10 rsp_valid after check"});
            expect_bit(rsp_replay, exp_replay, {req, " rsp_replay"});
        end
    endtask

    task automatic do_alloc(input logic [5:0] t, input logic [31:0] a);
        cyc(1'b1, t, a, 1'b0, 32'h0, 1'b0, 6'd0, 1'b0, "");
    endtask

    task automatic do_probe(input logic [31:0] a);
        cyc(1'b0, 6'd0, 32'h0, 1'b1, a, 1'b0, 6'd0, 1'b0, "");
    endtask

    task automatic do_check(input logic [5:0] t, input logic exp, input string req);
        cyc(1'b0, 6'd0, 32'h0, 1'b0, 32'h0, 1'b1, t, exp, req);
    endtask

    task automatic t_reset;
        expect_bit(rsp_valid, 1'b0, "R1 rsp_valid after reset");
        do_check(6'd3, 1'b1, "R1 R5 empty table check");
    endtask

    task automatic t_clean_check;
        do_alloc(6'd4, 32'h0000_1000);
        do_check(6'd4, 1'b0, "R2 untouched entry");
        do_check(6'd4, 1'b1, "R6 second check after consume");
    endtask

    task automatic t_conflict;
        do_alloc(6'd5, 32'h0000_2000);
        do_probe(32'h0000_2003);
        do_check(6'd5, 1'b1, "R3 store same word other byte");
        do_alloc(6'd6, 32'h0000_3000);
        do_probe(32'h0000_3004);
        do_check(6'd6, 1'b0, "R4 store to neighbour word");
    endtask

    task automatic t_same_cycle_alloc;
        cyc(1'b1, 6'd7, 32'h0000_4000, 1'b1, 32'h0000_4000, 1'b0, 6'd0, 1'b0, "");
        do_check(6'd7, 1'b0, "R8 store older than same-cycle load");
    endtask

    task automatic t_realloc;
        do_alloc(6'd8, 32'h0000_5000);
        do_probe(32'h0000_5000);
        do_alloc(6'd8, 32'h0000_6000);
        do_check(6'd8, 1'b0, "R9 reallocation clears mark");
        do_check(6'd8, 1'b1, "R9 single entry per tag");
    endtask

    task automatic t_probe_with_check;
        do_alloc(6'd9, 32'h0000_7000);
        cyc(1'b0, 6'd0, 32'h0, 1'b1, 32'h0000_7000, 1'b1, 6'd9, 1'b1,
            "R11 store older than same-cycle check");
    endtask

    task automatic t_idle_rsp;
        @(posedge clk);
        @(negedge clk);
        expect_bit(rsp_valid, 1'b0, "R10 rsp_valid low when idle");
    endtask

    task automatic t_evict;
        for (int i = 0; i < 16; i++) do_alloc(6'(10 + i), 32'h0001_0000 + 32'(i) * 32'h100);
        do_alloc(6'd40, 32'h0002_0000);               // evicts entry 0 (tag 10), pointer -> 1
        do_check(6'd10, 1'b1, "R7 evicted tag replays");
        do_check(6'd40, 1'b0, "R7 replacing entry live");
        do_alloc(6'd41, 32'h0002_0100);               // free slot 0, pointer stays 1
        do_check(6'd11, 1'b0, "R12 free slot used, pointer target kept");
        do_check(6'd41, 1'b0, "R12 entry in free slot live");
        do_alloc(6'd42, 32'h0002_0200);               // entry 0
        do_alloc(6'd43, 32'h0002_0300);               // entry 1, table full
        do_alloc(6'd44, 32'h0002_0400);               // evicts entry 1 (tag 43)
        do_check(6'd43, 1'b1, "R7 pointer advanced one step");
        do_check(6'd42, 1'b0, "R7 entry 0 not evicted");
        do_check(6'd12, 1'b0, "R7 entry 2 not evicted");
        do_check(6'd44, 1'b0, "R7 newest entry live");
    endtask

    initial begin
        rst = 1'b1;
        alloc_valid = 1'b0; alloc_tag = '0; alloc_addr = '0;
        probe_valid = 1'b0; probe_addr = '0;
        chk_valid = 1'b0; chk_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clean_check();
        t_conflict();
        t_same_cycle_alloc();
        t_realloc();
        t_probe_with_check();
        t_idle_rsp();
        t_evict();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule